// File: doc/BRIEF.md
# Machine-Cycle Clock Enable Generator

This block turns a single oscillator clock into a set of one-cycle clock-enable strobes. One strobe marks the CPU machine cycle. Eight more strobes pace the peripherals: timer 0, timer 1, timer 2, the UART, the counter array, the watchdog, the two-wire interface and SPI. Logic elsewhere in the chip runs on the oscillator clock and advances only in cycles where its strobe is high. No derived clocks are needed.

A global double-speed (X2) bit halves the machine cycle from 12 to 6 oscillator periods. While X2 is on, each peripheral has its own override bit. A set override keeps that peripheral at the slow 12-period rate. A clear override lets it follow the 6-period rate. The override bits have no effect while X2 is off.

A small byte-wide register port holds the two clock-control registers and a PLL control register. The PLL register drives the bypass and enable controls to the analog PLL, which sits outside this block. It also returns a lock flag taken from an external lock-status input.

Top module: `mcyc_clken_gen`

## Requirements
- R1: While reset is asserted, every strobe output is low. After reset, reads of addresses 0, 1 and 2 return 0x00, and the PLL bypass and enable outputs are low.
- R2: With X2 (address 0, bit 0) clear, `cpu_ce` is high for one cycle out of every 12 oscillator cycles.
- R3: With X2 set, `cpu_ce` is high for one cycle out of every 6 oscillator cycles.
- R4: With X2 clear, every `periph_ce` bit strobes once every 12 cycles, whatever the override bits hold.
- R5: With X2 set, a peripheral whose override is clear strobes every 6 cycles, and one whose override is set strobes every 12. Address 0 holds these overrides:
  - bit 1: timer 0, `periph_ce[0]`
  - bit 2: timer 1, `periph_ce[1]`
  - bit 3: timer 2, `periph_ce[2]`
  - bit 4: UART, `periph_ce[3]`
  - bit 5: counter array, `periph_ce[4]`
  - bit 6: watchdog, `periph_ce[5]`
  - bit 7: two-wire interface, `periph_ce[6]`
- R6: Address 1, bit 0 is the SPI override, which paces `periph_ce[7]`. Bits 7 to 1 of address 1 always read 0, whatever is written.
- R7: Address 2 holds the PLL bypass in bit 2 and the PLL enable in bit 1. These bits drive `pll_bypass` and `pll_en`. Bits 7 to 3 read 0, and a write to bit 0 has no effect.
- R8: Address 2, bit 0 reads the `pll_lock_in` value from two clock edges earlier while PLL enable is set, and reads 0 while PLL enable is clear.
- R9: A change of divide ratio takes effect at a strobe boundary. The gap between a strobe and the next one of the same output equals the ratio that was configured when the earlier strobe was launched. No strobe is ever high in two consecutive cycles.
- R10: Address 3 reads 0x00, and a write to it leaves addresses 0 to 2 unchanged.
- R11: Reads are combinational from `reg_addr`. A write is visible on `reg_rdata` in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control 0, 1 control 1, 2 PLL control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| pll_lock_in | input | 1 | Lock status from the analog PLL |
| pll_bypass | output | 1 | Selects the external 48 MHz clock and bypasses the PLL |
| pll_en | output | 1 | PLL enable |
| cpu_ce | output | 1 | Machine-cycle strobe |
| periph_ce | output | 8 | Peripheral strobes: timer 0, timer 1, timer 2, UART, counter array, watchdog, two-wire, SPI |

## Verification
A register read is due in the same cycle as its address. The bench therefore sets the address at the falling edge and samples 1 ns later. A write appears from the falling edge that follows the accepting rising edge.

Each strobe gap is due one configured ratio after the previous strobe. That ratio is the configuration held one cycle before that strobe was seen. For this reason the monitor pairs every strobe it observes with the shadow configuration from the previous falling edge, and not the current one.

The lock flag is due two rising edges after `pll_lock_in` changes. The bench samples it at both edges to pin that delay exactly.

// File: rtl/mcyc_clken_gen.sv
module mcyc_clken_gen #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 6,
  parameter int NPER     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            pll_lock_in,
  output logic            pll_bypass,
  output logic            pll_en,
  output logic            cpu_ce,
  output logic [NPER-1:0] periph_ce
);
  localparam int CW = $clog2(DIV_SLOW);
  localparam logic [CW-1:0] SLOW_M1 = CW'(DIV_SLOW - 1);
  localparam logic [CW-1:0] FAST_M1 = CW'(DIV_FAST - 1);
  localparam int NSTB = NPER + 1;

  logic [7:0] ctl0;
  logic       spi_ovr;
  logic [1:0] lock_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0       <= '0;
      spi_ovr    <= 1'b0;
      pll_bypass <= 1'b0;
      pll_en     <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: ctl0 <= reg_wdata;
        2'd1: spi_ovr <= reg_wdata[0];
        2'd2: {pll_bypass, pll_en} <= reg_wdata[2:1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock_sync <= '0;
    else        lock_sync <= {lock_sync[0], pll_lock_in};
  end

  wire x2 = ctl0[0];
  wire [NPER-1:0] ovr = {spi_ovr, ctl0[7:1]};

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctl0;
      2'd1:    reg_rdata = {7'd0, spi_ovr};
      2'd2:    reg_rdata = {5'd0, pll_bypass, pll_en, pll_en & lock_sync[1]};
      default: reg_rdata = 8'h00;
    endcase
  end

  logic [NSTB-1:0] stb;

  for (genvar g = 0; g < NSTB; g++) begin : g_div
    logic [CW-1:0] cnt;
    logic          ce_q;
    logic          fast;
    if (g == NPER) begin : g_cpu
      assign fast = x2;
    end else begin : g_per
      assign fast = x2 & ~ovr[g];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt  <= '0;
        ce_q <= 1'b0;
      end else begin
        ce_q <= (cnt == '0);
        cnt  <= (cnt == '0) ? (fast ? FAST_M1 : SLOW_M1) : cnt - 1'b1;
      end
    end
    assign stb[g] = ce_q;
  end

  assign periph_ce = stb[NPER-1:0];
  assign cpu_ce    = stb[NPER];
endmodule

// File: rtl/mcyc_clken_gen_chk.sv
module mcyc_clken_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       pll_en,
  input logic       pll_bypass,
  input logic       cpu_ce,
  input logic [7:0] periph_ce
);
  // R9
  cpu_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |=> !cpu_ce);

  // R9
  periph_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_ce != 8'd0) |=> ((periph_ce & $past(periph_ce)) == 8'd0));

  // R6
  ctl1_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[7:1] == 7'd0));

  // R8
  lock_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2 && !pll_en) |-> (reg_rdata[0] == 1'b0));

  // R7
  pll_ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 2'd2) |=> ($stable(pll_en) && $stable(pll_bypass)));

  // R10
  addr3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd3) |-> (reg_rdata == 8'h00));
endmodule

bind mcyc_clken_gen mcyc_clken_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .pll_en(pll_en), .pll_bypass(pll_bypass),
  .cpu_ce(cpu_ce), .periph_ce(periph_ce)
);

// File: tb/mcyc_clken_gen_tb.sv
`timescale 1ns/1ps
module mcyc_clken_gen_tb;
  logic clk = 0, rst_n = 0, reg_we = 0, pll_lock_in = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic pll_bypass, pll_en, cpu_ce;
  logic [7:0] periph_ce;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic [7:0] sh0 = 0, sh0_prev = 0;
  logic sh1 = 0, sh1_prev = 0;
  int last_seen [9];
  int exp_gap [9];
  bit seen [9];
  bit mon_on = 0;

  always #5 clk = ~clk;

  mcyc_clken_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_lock_in(pll_lock_in),
    .pll_bypass(pll_bypass), .pll_en(pll_en), .cpu_ce(cpu_ce), .periph_ce(periph_ce)
  );

  function automatic int ratio_of(int idx, logic [7:0] c0, logic c1);
    logic ov;
    if (!c0[0]) return 12;
    if (idx == 8) return 6;
    ov = (idx == 7) ? c1 : c0[idx+1];
    return ov ? 12 : 6;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R2 R3 R4 R5 R6 R9: strobe gap monitor
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      cyc++;
      for (int i = 0; i < 9; i++) begin
        logic ce;
        ce = (i == 8) ? cpu_ce : periph_ce[i];
        if (ce) begin
          if (seen[i])
            check(cyc - last_seen[i] == exp_gap[i], $sformatf("R9 gap strobe %0d", i),
                  cyc - last_seen[i], exp_gap[i]);
          last_seen[i] = cyc;
          exp_gap[i]   = ratio_of(i, sh0_prev, sh1_prev);
          seen[i]      = 1;
        end else if (seen[i] && (cyc - last_seen[i] > exp_gap[i])) begin
          check(0, $sformatf("R9 missing strobe %0d", i), cyc - last_seen[i], exp_gap[i]);
          seen[i] = 0;
        end
      end
    end
    sh0_prev = sh0;
    sh1_prev = sh1;
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    if (a == 2'd0) sh0 = d;
    if (a == 2'd1) sh1 = d[0];
    reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // count strobes of one output over a window and check the period
  task automatic period_chk(int idx, int expv, string req);
    int first, second, n;
    first = -1; second = -1; n = 0;
    while (second < 0 && n < 40) begin
      @(negedge clk); #1;
      if ((idx == 8 ? cpu_ce : periph_ce[idx])) begin
        if (first < 0) first = n; else second = n;
      end
      n++;
    end
    check(second - first == expv, req, second - first, expv);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    repeat (3) begin
      @(negedge clk);
      check(cpu_ce == 0 && periph_ce == 0, "R1 strobes low in reset", {cpu_ce, periph_ce}, 0);
    end
    @(negedge clk) rst_n = 1;
    rd(2'd0, d); check(d == 8'h00, "R1 ctl0 reset", d, 0);
    rd(2'd1, d); check(d == 8'h00, "R1 ctl1 reset", d, 0);
    rd(2'd2, d); check(d == 8'h00, "R1 pll reset", d, 0);
    check(pll_en == 0 && pll_bypass == 0, "R1 pll outputs", {pll_bypass, pll_en}, 0);
    mon_on = 1;

    period_chk(8, 12, "R2 cpu slow");
    wr(2'd0, 8'hFE);
    repeat (14) @(negedge clk);
    period_chk(0, 12, "R4 override ignored while X2 clear");
    wr(2'd0, 8'h01);
    repeat (14) @(negedge clk);
    period_chk(8, 6, "R3 cpu fast");
    period_chk(3, 6, "R5 uart fast");
    wr(2'd0, 8'h41);
    repeat (14) @(negedge clk);
    period_chk(5, 12, "R5 watchdog override slow");
    period_chk(6, 6, "R5 two-wire fast");
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check(d == 8'h01, "R6 ctl1 upper bits zero", d, 1);
    repeat (14) @(negedge clk);
    period_chk(7, 12, "R6 spi override slow");

    wr(2'd2, 8'hFF);
    rd(2'd2, d); check(d == 8'h06, "R7 pll reg write, lock low", d, 6);
    check(pll_en == 1 && pll_bypass == 1, "R7 pll outputs", {pll_bypass, pll_en}, 3);
    @(negedge clk) pll_lock_in = 1;
    @(negedge clk); #1; reg_addr = 2'd2; #1;
    check(reg_rdata[0] == 0, "R8 lock after one edge", reg_rdata[0], 0);
    @(negedge clk); #1;
    check(reg_rdata[0] == 1, "R8 lock after two edges", reg_rdata[0], 1);
    wr(2'd2, 8'h04);
    rd(2'd2, d); check(d == 8'h04, "R8 lock gated by enable", d, 4);
    check(pll_en == 0, "R7 pll_en cleared", pll_en, 0);

    wr(2'd3, 8'hAA);
    rd(2'd3, d); check(d == 8'h00, "R10 addr3 reads zero", d, 0);
    rd(2'd0, d); check(d == sh0, "R10 ctl0 unchanged", d, sh0);
    rd(2'd1, d); check(d == {7'd0, sh1}, "R10 ctl1 unchanged", d, sh1);
    rd(2'd2, d); check(d == 8'h04, "R10 pll unchanged", d, 4);

    for (int k = 0; k < 60; k++) begin
      logic [7:0] v;
      v = 8'($urandom);
      if ($urandom % 3 == 0) wr(2'd1, v); else wr(2'd0, v);
      rd(($urandom % 2 == 0) ? 2'd0 : 2'd1, d);
      if (reg_addr == 2'd0) check(d == sh0, "R11 ctl0 readback", d, sh0);
      else check(d == {7'd0, sh1}, "R11 ctl1 readback", d, sh1);
      repeat ($urandom % 30) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule